// File: doc/BRIEF.md
# Serial-Bus Word Timer with Sync-Length Reset

This block lives in every peripheral device on a bit-serial bus, for example a program memory. The bus master drives a single SYNC line. The block watches that line to keep a local bit-position counter in step with the master. Each word on the bus is 56 bit times long. In a word that carries an instruction, SYNC is high for its first 10 bit times.

The counter runs freely through words in which SYNC stays low, such as the second word of a two-word instruction. The first bits of such a word hold a branch target, so the block flags them separately and they are not read as an instruction. SYNC is sampled only on clock edges that carry the phase-2 qualifier, so short pulses that fall outside phase 2 have no effect.

The block has no system-reset pin. Instead, it treats SYNC seen high for more than 10 bit times in a row as a system reset. While that reset is active, a small memory-bank register is held at bank 0. The same register otherwise loads a new bank number when its write strobe is pulsed.

Top module: `wst_top`

## Requirements
- R1: While `rst_n` is low, `bit_idx` is 0, `instr_win`, `branch_win` and `sys_rst` are 0, and `bank_sel` is 0.
- R2: State changes only on rising `clk` edges where `ph2_en` is 1. A high `sync_in` on edges where `ph2_en` is 0 leaves every output unchanged.
- R3: A qualified edge that samples `sync_in` high, after the previous qualified sample was low, sets `bit_idx` to 0 and raises `instr_win` after that edge.
- R4: Once synchronised, `bit_idx` rises by 1 on each qualified edge and wraps from 55 to 0. This continues even when no SYNC rise arrives.
- R5: `instr_win` is 1 for `bit_idx` 0 to 9 of a word that began with a SYNC rise. `branch_win` is 1 for `bit_idx` 0 to 9 of a word that began by wrapping without a rise. The two flags are never 1 together.
- R6: The 11th consecutive qualified high sample of `sync_in` raises `sys_rst` after that edge. The same edge clears `bit_idx` to 0 and drops both window flags. A high run of exactly 10 samples does not raise `sys_rst`.
- R7: `sys_rst` stays 1 until a qualified edge samples `sync_in` low, and falls after that edge. Afterwards the block stays unsynchronised (`bit_idx` 0, no window) until the next SYNC rise.
- R8: On a qualified edge with `bank_wr` 1, `bank_sel` loads `bank_din`. This happens only when `sys_rst` is 0 and the edge is not the one that raises `sys_rst`; in those two cases `bank_sel` is forced to 0 and the write is dropped.
- R9: After `rst_n` is released and before the first SYNC rise, `bit_idx` stays 0 and neither window flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the local logic |
| ph2_en | input | 1 | Phase-2 qualifier; marks the clock edges that count as bit times |
| sync_in | input | 1 | Word-sync line from the bus master |
| bank_wr | input | 1 | Strobe that loads a new bank number |
| bank_din | input | BANK_W (2) | Bank number to load |
| bit_idx | output | 6 | Current bit position within the word, 0 to 55 |
| instr_win | output | 1 | First 10 bits of a word that carries an instruction |
| branch_win | output | 1 | First 10 bits of a word that carries a branch target |
| sys_rst | output | 1 | System reset derived from an overlong SYNC |
| bank_sel | output | BANK_W (2) | Currently selected memory bank |

## Verification
Two functions can act on the same bit time. The first is a bank-write strobe arriving on the very edge that detects the 11th high SYNC sample. The second is a write arriving while the reset is still held. The bench raises `bank_wr` with a new value on exactly those edges and expects `bank_sel` to read 0. A second write after SYNC falls must then take effect.

The bench also places a SYNC rise in the middle of a running word, so that a resynchronisation competes with the free-running increment. The rise must win, and a behavioural model checks every output on every cycle.

// File: rtl/wst_pkg.sv
package wst_pkg;

  // Per-bit-time events produced by the SYNC sampler.
  typedef struct packed {
    logic rise;   // qualified low-to-high transition of SYNC
    logic fire;   // this qualified edge detects an overlong SYNC
    logic hold;   // reset currently held (registered)
  } sync_evt_t;

endpackage

// File: rtl/wst_sync_sampler.sv
module wst_sync_sampler
  import wst_pkg::*;
#(
  parameter int SYNC_BITS = 10
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ph2_en,
  input  logic      sync_in,
  output logic      sync_q,
  output sync_evt_t evt
);

  localparam int RUN_W = $clog2(SYNC_BITS + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(SYNC_BITS);

  logic [RUN_W-1:0] run_q, run_d;
  logic             sync_d;
  logic             hold_q, hold_d;
  logic             fire;

  // A high sample with SYNC_BITS highs already behind it is one too many.
  assign fire = ph2_en & sync_in & (run_q == RUN_MAX) & ~hold_q;

  always_comb begin
    run_d  = run_q;
    sync_d = sync_q;
    hold_d = hold_q;
    if (ph2_en) begin
      sync_d = sync_in;
      if (!sync_in) begin
        run_d  = '0;
        hold_d = 1'b0;
      end else begin
        if (run_q != RUN_MAX) run_d = run_q + 1'b1;
        if (fire)             hold_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      sync_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (ph2_en) begin
      run_q  <= run_d;
      sync_q <= sync_d;
      hold_q <= hold_d;
    end
  end

  always_comb begin
    evt.rise = ph2_en & sync_in & ~sync_q & ~hold_q;
    evt.fire = fire;
    evt.hold = hold_q;
  end

  // R6: the high-run count never exceeds its saturation value
  a_r6_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX);

  // R7: a held reset is dropped by a low qualified sample
  a_r7_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && ph2_en && !sync_in) |=> !hold_q);

endmodule

// File: rtl/wst_bit_counter.sv
module wst_bit_counter
  import wst_pkg::*;
#(
  parameter int WORD_BITS = 56,
  parameter int SYNC_BITS = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ph2_en,
  input  sync_evt_t                    evt,
  output logic [$clog2(WORD_BITS)-1:0] bit_idx,
  output logic                         instr_win,
  output logic                         branch_win
);

  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(WORD_BITS - 1);
  localparam logic [CNT_W-1:0] WIN_END = CNT_W'(SYNC_BITS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             synced_q, synced_d;
  logic             is_instr_q, is_instr_d;
  logic             in_window;

  always_comb begin
    cnt_d      = cnt_q;
    synced_d   = synced_q;
    is_instr_d = is_instr_q;
    if (ph2_en) begin
      if (evt.hold || evt.fire) begin
        cnt_d      = '0;
        synced_d   = 1'b0;
        is_instr_d = 1'b0;
      end else if (evt.rise) begin
        cnt_d      = '0;
        synced_d   = 1'b1;
        is_instr_d = 1'b1;
      end else if (synced_q) begin
        if (cnt_q == LAST) begin
          cnt_d      = '0;
          is_instr_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      synced_q   <= 1'b0;
      is_instr_q <= 1'b0;
    end else if (ph2_en) begin
      cnt_q      <= cnt_d;
      synced_q   <= synced_d;
      is_instr_q <= is_instr_d;
    end
  end

  assign in_window  = synced_q & (cnt_q < WIN_END);
  assign instr_win  = in_window & is_instr_q;
  assign branch_win = in_window & ~is_instr_q;
  assign bit_idx    = cnt_q;

  // R4: the counter never leaves the word range
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R9: an unsynchronised counter sits at zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !synced_q |-> cnt_q == '0);

endmodule

// File: rtl/wst_bank_reg.sv
module wst_bank_reg #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph2_en,
  input  logic              clr,
  input  logic              wr,
  input  logic [BANK_W-1:0] din,
  output logic [BANK_W-1:0] bank
);

  logic [BANK_W-1:0] bank_d;

  always_comb begin
    bank_d = bank;
    if (clr)     bank_d = '0;
    else if (wr) bank_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bank <= '0;
    else if (ph2_en) bank <= bank_d;
  end

  // R8: a clear on a qualified edge always wins over a write
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2_en && clr) |=> bank == '0);

endmodule

// File: rtl/wst_top.sv
module wst_top
  import wst_pkg::*;
#(
  parameter int WORD_BITS = 56,
  parameter int SYNC_BITS = 10,
  parameter int BANK_W    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ph2_en,
  input  logic                         sync_in,
  input  logic                         bank_wr,
  input  logic [BANK_W-1:0]            bank_din,
  output logic [$clog2(WORD_BITS)-1:0] bit_idx,
  output logic                         instr_win,
  output logic                         branch_win,
  output logic                         sys_rst,
  output logic [BANK_W-1:0]            bank_sel
);

  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  sync_evt_t evt;
  logic      sync_q;

  wst_sync_sampler #(.SYNC_BITS(SYNC_BITS)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .ph2_en  (ph2_en),
    .sync_in (sync_in),
    .sync_q  (sync_q),
    .evt     (evt)
  );

  wst_bit_counter #(.WORD_BITS(WORD_BITS), .SYNC_BITS(SYNC_BITS)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .ph2_en     (ph2_en),
    .evt        (evt),
    .bit_idx    (bit_idx),
    .instr_win  (instr_win),
    .branch_win (branch_win)
  );

  wst_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph2_en (ph2_en),
    .clr    (evt.hold | evt.fire),
    .wr     (bank_wr),
    .din    (bank_din),
    .bank   (bank_sel)
  );

  assign sys_rst = evt.hold;

  // R2: without the phase-2 qualifier nothing moves
  a_r2_ph2_only: assert property (@(posedge clk) disable iff (!rst_n)
    !ph2_en |=> ($stable(bit_idx) && $stable(sys_rst) && $stable(bank_sel)));

  // R3: a sampled SYNC rise starts an instruction word at bit 0
  a_r3_rise_align: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2_en && sync_in && !sync_q && !sys_rst) |=> (bit_idx == '0 && instr_win));

  // R4: free-running advance inside a window when SYNC is low
  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2_en && !sync_in && (instr_win || branch_win)) |=> bit_idx == $past(bit_idx) + 1'b1);

  // R4: a wrap without SYNC opens a branch-target window
  a_r4_wrap_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2_en && !sync_in && bit_idx == LAST) |=> (bit_idx == '0 && branch_win));

  // R5: at most one window flag at a time
  a_r5_one_window: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({instr_win, branch_win}));

  // R6: reset only ever rises from a qualified high SYNC sample
  a_r6_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(ph2_en && sync_in));

  // R7: reset ends on a qualified low SYNC sample
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && ph2_en && !sync_in) |=> !sys_rst);

  // R8: the bank reads zero throughout reset
  a_r8_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> bank_sel == '0);

  // R9: no window while reset is held
  a_r9_no_window_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> (!instr_win && !branch_win && bit_idx == '0));

endmodule

// File: tb/wst_top_tb.sv
module wst_top_tb;

  localparam int WORD_BITS = 56;
  localparam int SYNC_BITS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ph2_en = 1'b0;
  logic       sync_in = 1'b0;
  logic       bank_wr = 1'b0;
  logic [1:0] bank_din = '0;
  logic [5:0] bit_idx;
  logic       instr_win, branch_win, sys_rst;
  logic [1:0] bank_sel;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wst_top u_dut (
    .clk(clk), .rst_n(rst_n), .ph2_en(ph2_en), .sync_in(sync_in),
    .bank_wr(bank_wr), .bank_din(bank_din), .bit_idx(bit_idx),
    .instr_win(instr_win), .branch_win(branch_win), .sys_rst(sys_rst),
    .bank_sel(bank_sel)
  );

  // Behavioural reference: history of qualified SYNC samples plus word state
  bit    hist[$];
  int    m_pos;
  bit    m_locked, m_instr_word, m_rst;
  int    m_bank;

  function automatic int high_run();
    int n = 0;
    for (int i = hist.size() - 1; i >= 0 && hist[i]; i--) n++;
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      m_pos = 0; m_locked = 0; m_instr_word = 0; m_rst = 0; m_bank = 0;
    end else if (ph2_en) begin
      bit prev, trig, edge_up;
      prev    = (hist.size() > 0) ? hist[hist.size()-1] : 1'b0;
      trig    = sync_in && !m_rst && high_run() >= SYNC_BITS;
      edge_up = sync_in && !prev && !m_rst;
      if (m_rst || trig)   m_bank = 0;
      else if (bank_wr)    m_bank = int'(bank_din);
      if (m_rst || trig) begin
        m_locked = 0; m_pos = 0; m_instr_word = 0;
      end else if (edge_up) begin
        m_locked = 1; m_pos = 0; m_instr_word = 1;
      end else if (m_locked) begin
        m_pos = (m_pos + 1) % WORD_BITS;
        if (m_pos == 0) m_instr_word = 0;
      end
      if (!sync_in) m_rst = 0;
      else if (trig) m_rst = 1;
      hist.push_back(sync_in);
      if (hist.size() > 64) void'(hist.pop_front());
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      bit ew, eb;
      ew = m_locked && m_instr_word && m_pos < SYNC_BITS;
      eb = m_locked && !m_instr_word && m_pos < SYNC_BITS;
      check(int'(bit_idx) == m_pos, "R4 bit_idx", int'(bit_idx), m_pos);
      check(instr_win == ew, "R5 instr_win", int'(instr_win), int'(ew));
      check(branch_win == eb, "R5 branch_win", int'(branch_win), int'(eb));
      check(sys_rst == m_rst, "R6 sys_rst", int'(sys_rst), int'(m_rst));
      check(int'(bank_sel) == m_bank, "R8 bank_sel", int'(bank_sel), m_bank);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step(input bit s, input bit p = 1'b1, input bit w = 1'b0,
                      input logic [1:0] d = 2'd0);
    sync_in = s; ph2_en = p; bank_wr = w; bank_din = d;
    @(negedge clk);
  endtask

  task automatic word(input int highs);
    for (int i = 0; i < WORD_BITS; i++) step(i < highs);
  endtask

  initial begin
    int held;
    repeat (3) @(negedge clk);
    check(bit_idx == 0 && !instr_win && !branch_win && !sys_rst && bank_sel == 0,
          "R1 reset state", int'(bit_idx), 0);
    rst_n = 1'b1;
    repeat (5) step(1'b0);
    check(bit_idx == 0 && !instr_win && !branch_win, "R9 unsynced idle",
          int'(instr_win | branch_win), 0);

    step(1'b1);
    check(bit_idx == 0 && instr_win, "R3 first rise", int'(bit_idx), 0);
    for (int i = 1; i < WORD_BITS; i++) step(i < SYNC_BITS);
    check(bit_idx == 55, "R4 end of word", int'(bit_idx), 55);
    check(!sys_rst, "R6 ten highs no reset", int'(sys_rst), 0);

    word(SYNC_BITS);
    step(1'b0);
    check(bit_idx == 0 && branch_win && !instr_win, "R5 branch word",
          int'(branch_win), 1);
    for (int i = 1; i < WORD_BITS; i++) step(1'b0);

    // SYNC high between qualified edges is ignored
    held = int'(bit_idx);
    repeat (3) step(1'b1, 1'b0);
    check(int'(bit_idx) == held && !instr_win, "R2 unqualified sync",
          int'(bit_idx), held);
    step(1'b0);
    check(bit_idx == 0 && branch_win, "R4 wrap after gap", int'(bit_idx), 0);

    step(1'b0, 1'b1, 1'b1, 2'd2);
    check(bank_sel == 2, "R8 bank load", int'(bank_sel), 2);

    // Mid-word resync
    repeat (17) step(1'b0);
    step(1'b1);
    check(bit_idx == 0 && instr_win, "R3 mid-word rise", int'(bit_idx), 0);
    for (int i = 1; i < WORD_BITS; i++) step(i < SYNC_BITS);

    // Alternating qualifier within a word
    for (int i = 0; i < 2 * WORD_BITS; i++) step(i < 2 * SYNC_BITS && i % 2 == 0, i[0] == 1'b0);

    // Overlong SYNC with a bank write on the detecting edge
    word(SYNC_BITS);
    for (int i = 0; i < SYNC_BITS; i++) step(1'b1);
    check(!sys_rst, "R6 no reset at ten", int'(sys_rst), 0);
    step(1'b1, 1'b1, 1'b1, 2'd3);
    check(sys_rst && bank_sel == 0, "R8 write on firing edge", int'(bank_sel), 0);
    check(bit_idx == 0 && !instr_win, "R6 counter cleared", int'(bit_idx), 0);
    step(1'b1, 1'b1, 1'b1, 2'd1);
    check(bank_sel == 0, "R8 write while held", int'(bank_sel), 0);
    repeat (5) step(1'b1);
    check(sys_rst, "R7 held while high", int'(sys_rst), 1);
    step(1'b0);
    check(!sys_rst && bit_idx == 0 && !branch_win, "R7 release", int'(sys_rst), 0);
    repeat (4) step(1'b0);
    check(bit_idx == 0 && !instr_win && !branch_win, "R7 unsynced after release",
          int'(bit_idx), 0);
    step(1'b0, 1'b1, 1'b1, 2'd1);
    check(bank_sel == 1, "R8 write after release", int'(bank_sel), 1);

    word(SYNC_BITS);
    word(0);
    word(SYNC_BITS);
    step(1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule